// File: doc/BRIEF.md
# Code Memory Lock Protection Unit

This block sits beside a microcontroller core and decides which accesses to the on-chip code memory are allowed. Three lock bits, each either clear or programmed, are turned into a two-bit protection level. Each step up the level adds to the restrictions of the level below it. Each cycle the core or the programming logic raises request strobes for four kinds of access: a table read issued by code that runs from external memory, a byte program, a verify read, and execution from external memory. For every strobe, the unit answers with exactly one of two signals, allow or deny.

The lock bits are held in a register. While reset is low, that register loads the stored non-volatile pattern. After reset, a programming write can only set bits and can never clear them. At any level above zero, the unit also captures the external-access pin while reset is low. It raises a mismatch flag whenever the captured value and the live pin level disagree. Before the first reset after power-up, the captured value is arbitrary.

Top module: `lockprot_top`

## Requirements
- R1: While `rst_n` is low, the lock register loads `nv_lock`. Bit value 1 means programmed. Bit 0 is the first lock bit.
- R2: While `lk_wr_en` is high out of reset, the lock register becomes its old value ORed with `lk_wr_bits` at the next clock edge. A write that tries to clear a bit has no effect on that bit.
- R3: `prot_level` is 0 when no lock bit is programmed. Otherwise it is one plus the index of the highest programmed bit. So any pattern that has bit 2 set gives 3, even if the lower bits are clear, and this is the fail-safe rule.
- R4: At level 0, every request is allowed.
- R5: At level 1 or above, table reads from external code (request index 0) and programming (index 1) are denied.
- R6: At level 2 or above, verify reads (index 2) are also denied.
- R7: At level 3, external execution (index 3) is also denied.
- R8: For each request index, `allow` and `deny` are never high together. Both are low when that request is low.
- R9: While `rst_n` is low, `ea_pin` is captured. The captured value is held unchanged until the next reset.
- R10: `ea_mismatch` is high exactly when the level is at least 1 and the captured value differs from the live `ea_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads lock bits and captures the pin |
| nv_lock | input | 3 | Stored lock pattern, 1 = programmed |
| lk_wr_en | input | 1 | Lock programming write strobe |
| lk_wr_bits | input | 3 | Bits to program (1 sets, 0 leaves unchanged) |
| ea_pin | input | 1 | Live external-access pin level |
| req | input | 4 | Requests: 0 table read, 1 program, 2 verify, 3 external execute |
| allow | output | 4 | Request granted, per index |
| deny | output | 4 | Request refused, per index |
| prot_level | output | 2 | Protection level 0..3 |
| ea_mismatch | output | 1 | Captured pin level differs from live level |

## Verification
The assertions check on every cycle that:
- allow and deny are exclusive and only answer a raised request;
- each protection level blocks what it must;
- the level never falls outside reset;
- the mismatch flag stays low at level 0 and changes only when the pin or the level changes.

Some behaviours only the bench's sweeps can show. These are the exact level for all eight lock patterns and the correct grant for every request combination at every level. They also include the OR-only effect of all 64 start/write pairs and the mismatch value for both captured pin levels against both live levels.

// File: rtl/lockprot_pkg.sv
// Shared constants and functions for the code memory lock protection unit.
// Assumes three lock bits and four request kinds; indices below are fixed.
package lockprot_pkg;
    localparam int LB_W   = 3;
    localparam int LVL_W  = 2;
    localparam int NREQ   = 4;
    localparam int RQ_TBL = 0;
    localparam int RQ_PRG = 1;
    localparam int RQ_VFY = 2;
    localparam int RQ_XEX = 3;

    // Highest programmed bit plus one; zero when no bit is programmed.
    function automatic logic [LVL_W-1:0] level_of(input logic [LB_W-1:0] bits);
        logic [LVL_W-1:0] lvl;
        lvl = '0;
        for (int i = 0; i < LB_W; i++) begin
            if (bits[i]) lvl = LVL_W'(i + 1);
        end
        return lvl;
    endfunction

    // Lowest level at which a request kind is refused.
    function automatic logic [LVL_W-1:0] block_from(input int r);
        case (r)
            RQ_TBL, RQ_PRG: return LVL_W'(1);
            RQ_VFY:         return LVL_W'(2);
            default:        return LVL_W'(3);
        endcase
    endfunction
endpackage

// File: rtl/lockprot_bits.sv
// Lock bit register: one sticky cell per bit.
// Loads the stored pattern while reset is low; afterwards writes may only set bits.
module lockprot_bits
    import lockprot_pkg::*;
#(
    parameter int W = LB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] nv_lock,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bits,
    output logic [W-1:0] lock_q
);
    for (genvar g = 0; g < W; g++) begin : g_cell
        // Sticky cell: reload on reset, set-only on write.
        always_ff @(posedge clk) begin
            if (!rst_n)                  lock_q[g] <= nv_lock[g];
            else if (wr_en && wr_bits[g]) lock_q[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/lockprot_ea.sv
// External-access pin capture and mismatch detection.
// Assumes the captured value is meaningful only after a reset; before that it is arbitrary.
module lockprot_ea
    import lockprot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ea_pin,
    input  logic [LVL_W-1:0] level,
    output logic             mismatch
);
    logic ea_q;

    // Capture the pin level while reset is held low.
    always_ff @(posedge clk) begin
        if (!rst_n) ea_q <= ea_pin;
    end

    // Flag disagreement only when some protection is active.
    always_comb mismatch = (level != '0) && (ea_q != ea_pin);
endmodule

// File: rtl/lockprot_gate.sv
// Per-request gating: compares the protection level with each request's block level.
// Pure combinational; every raised request gets exactly one of allow or deny.
module lockprot_gate
    import lockprot_pkg::*;
#(
    parameter int N = NREQ
) (
    input  logic [LVL_W-1:0] level,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     allow,
    output logic [N-1:0]     deny
);
    for (genvar g = 0; g < N; g++) begin : g_req
        logic ok;
        // Request passes while the level is below its block threshold.
        always_comb begin
            ok       = level < block_from(g);
            allow[g] = req[g] && ok;
            deny[g]  = req[g] && !ok;
        end
    end
endmodule

// File: rtl/lockprot_top.sv
// Code memory lock protection unit top level.
// Ties the lock register, level decode, request gates and pin capture together.
module lockprot_top
    import lockprot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LB_W-1:0]  nv_lock,
    input  logic             lk_wr_en,
    input  logic [LB_W-1:0]  lk_wr_bits,
    input  logic             ea_pin,
    input  logic [NREQ-1:0]  req,
    output logic [NREQ-1:0]  allow,
    output logic [NREQ-1:0]  deny,
    output logic [LVL_W-1:0] prot_level,
    output logic             ea_mismatch
);
    logic [LB_W-1:0] lock_q;

    lockprot_bits #(.W(LB_W)) u_bits (
        .clk(clk), .rst_n(rst_n), .nv_lock(nv_lock),
        .wr_en(lk_wr_en), .wr_bits(lk_wr_bits), .lock_q(lock_q)
    );

    // Fail-safe level decode from the stored bits.
    always_comb prot_level = level_of(lock_q);

    lockprot_gate #(.N(NREQ)) u_gate (
        .level(prot_level), .req(req), .allow(allow), .deny(deny)
    );

    lockprot_ea u_ea (
        .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin),
        .level(prot_level), .mismatch(ea_mismatch)
    );
endmodule

// File: rtl/lockprot_chk.sv
// Checker for the lock protection unit, attached to every instance by bind.
module lockprot_chk
    import lockprot_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ea_pin,
    input logic [NREQ-1:0]  req,
    input logic [NREQ-1:0]  allow,
    input logic [NREQ-1:0]  deny,
    input logic [LVL_W-1:0] prot_level,
    input logic             ea_mismatch
);
    // R8
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n) (allow & deny) == '0);
    // R8
    noreq_chk: assert property (@(posedge clk) disable iff (!rst_n) ((allow | deny) & ~req) == '0);
    // R5
    lvl1_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_level >= 2'd1) |-> (!allow[RQ_TBL] && !allow[RQ_PRG]));
    // R6
    lvl2_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_level >= 2'd2) |-> !allow[RQ_VFY]);
    // R7
    lvl3_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_level == 2'd3) |-> !allow[RQ_XEX]);
    // R4
    lvl0_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_level == 2'd0) |-> (allow == req));
    // R2
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (prot_level >= $past(prot_level)));
    // R10
    lvl0_nomis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_level == 2'd0) |-> !ea_mismatch);
    // R9
    ea_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(ea_pin) && $stable(prot_level)) |-> $stable(ea_mismatch));
endmodule

bind lockprot_top lockprot_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .req(req), .allow(allow),
    .deny(deny), .prot_level(prot_level), .ea_mismatch(ea_mismatch)
);

// File: tb/tb_lockprot_top.sv
module tb_lockprot_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] nv_lock;
    logic       lk_wr_en;
    logic [2:0] lk_wr_bits;
    logic       ea_pin;
    logic [3:0] req;
    logic [3:0] allow, deny;
    logic [1:0] prot_level;
    logic       ea_mismatch;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lockprot_top dut (
        .clk(clk), .rst_n(rst_n), .nv_lock(nv_lock), .lk_wr_en(lk_wr_en),
        .lk_wr_bits(lk_wr_bits), .ea_pin(ea_pin), .req(req), .allow(allow),
        .deny(deny), .prot_level(prot_level), .ea_mismatch(ea_mismatch)
    );

    function automatic int exp_lvl(input int b);
        if (b >= 4) return 3;
        if (b >= 2) return 2;
        if (b >= 1) return 1;
        return 0;
    endfunction

    // Allowed-mask for a level, computed from per-request thresholds 1,1,2,3.
    function automatic int ok_mask(input int lvl);
        int m;
        m = 0;
        if (lvl < 1) m += 3;
        if (lvl < 2) m += 4;
        if (lvl < 3) m += 8;
        return m;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic do_reset(input int nv, input int ea);
        @(negedge clk);
        rst_n = 1'b0; nv_lock = 3'(nv); ea_pin = ea[0]; lk_wr_en = 1'b0; req = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; nv_lock = '0; lk_wr_en = 1'b0; lk_wr_bits = '0; ea_pin = 1'b0; req = '0;
        // R1, R3 through R8 and R10: every pattern, pin capture and request mix
        for (int nv = 0; nv < 8; nv++) begin
            for (int ea = 0; ea < 2; ea++) begin
                do_reset(nv, ea);
                #1;
                chk("R1_R3 level", int'(prot_level), exp_lvl(nv));
                for (int r = 0; r < 16; r++) begin
                    req = 4'(r);
                    #1;
                    chk("R4_R5_R6_R7 allow", int'(allow), r & ok_mask(exp_lvl(nv)));
                    chk("R8 deny", int'(deny), r & ~ok_mask(exp_lvl(nv)) & 15);
                end
                // R9 R10: live pin equal, then opposite to the captured value
                chk("R10 mis_same", int'(ea_mismatch), 0);
                @(negedge clk); ea_pin = ~ea[0];
                #1;
                chk("R10 mis_diff", int'(ea_mismatch), (exp_lvl(nv) > 0) ? 1 : 0);
                @(negedge clk); @(negedge clk);
                chk("R9 hold", int'(ea_mismatch), (exp_lvl(nv) > 0) ? 1 : 0);
                ea_pin = ea[0];
                #1;
                chk("R9 back", int'(ea_mismatch), 0);
            end
        end
        // R2: every start pattern against every write pattern; only OR survives
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 8; w++) begin
                do_reset(s, 0);
                lk_wr_bits = 3'(w); lk_wr_en = 1'b1;
                @(negedge clk);
                lk_wr_en = 1'b0; req = 4'hF;
                #1;
                chk("R2 level", int'(prot_level), exp_lvl(s | w));
                chk("R2 allow", int'(allow), ok_mask(exp_lvl(s | w)));
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog got=0 exp=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule